// File: doc/BRIEF.md
# Pulse Timer with Two-Channel Steering

This block turns a single-cycle cycle-start strobe from an oscillator into one gate-drive pulse of programmed length. A toggle bit steers the pulse to drive channel A or drive channel B. The toggle advances whenever a pulse ends, including a pulse cut short by a fault. A mode input chooses between two patterns. In the alternating pattern the channels take turns. In the unison pattern both channels fire on every pulse.

A recovery interval, also programmed as a clock count, follows every pulse. The block stays busy for the whole recovery interval and ignores new strobes until it is over, which caps the repetition rate. A lockout input parks the block in a safe state: both drives go low, the block goes idle, and channel A is set to fire next. A fault input ends a running pulse at the next clock edge.

Counts are in clock cycles. The on-time count, the recovery count and the mode are all captured when a pulse starts.

Top module: `pulse_steer_top`

## Requirements
- R1: After reset, and after any cycle with lockout high, drv_a_o, drv_b_o and busy_o are 0, and the first pulse that follows goes to channel A.
- R2: A start_i strobe sampled while the block is idle, with lockout and fault both low, sets the selected drive high from the next cycle. The drive stays high for exactly N cycles, where N is the on-time count, and busy_o is high for all of those cycles.
- R3: An on-time count of 0 gives a 1-cycle pulse. A recovery count of 0 gives a 1-cycle recovery.
- R4: With unison_i = 0 at pulse start, pulses go to A, then B, then A, and so on. The two drives are never high together.
- R5: With unison_i = 1 at pulse start, drv_a_o and drv_b_o are high in exactly the same cycles.
- R6: After a pulse, both drives are low and busy_o stays high for exactly D cycles, where D is the recovery count. busy_o then falls for at least one cycle. A start_i strobe during the pulse or the recovery has no effect.
- R7: on_cnt_i and dead_cnt_i are captured at pulse start. Changing them afterwards does not alter the running pulse or the recovery that follows it.
- R8: abort_i high during a pulse drives both outputs low at the next edge. The recovery interval then runs in full, and the toggle advances as if the pulse had ended normally. A strobe arriving with abort_i high is ignored.
- R9: lockout_i high forces both drives low and busy_o low at the next edge, even in the middle of a pulse. A start_i strobe while lockout_i is high is ignored.
- R10: With start_i held high, the block free-runs with a period of N + D + 1 cycles.
- R11: The mode is captured at pulse start. Changing unison_i during a pulse does not change which drives are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Cycle-start strobe from the oscillator |
| unison_i | input | 1 | 1 = both channels per pulse, 0 = alternate |
| on_cnt_i | input | CNT_W | Pulse length in cycles (0 acts as 1) |
| dead_cnt_i | input | CNT_W | Recovery length in cycles (0 acts as 1) |
| lockout_i | input | 1 | Forces safe state, preloads channel A |
| abort_i | input | 1 | Fault: ends the running pulse |
| drv_a_o | output | 1 | Registered drive, channel A |
| drv_b_o | output | 1 | Registered drive, channel B |
| busy_o | output | 1 | High during pulse and recovery |

## Verification
The assertions check on every cycle the properties that hold at all times:
- the two drives are never high together in alternating mode, and always match in unison mode;
- a drive is never high unless busy_o is high;
- lockout and abort empty the outputs at the next edge;
- a new pulse never begins straight out of recovery.

Some behaviour only the bench scenarios can show: exact pulse and recovery lengths across a sweep of counts, the zero-count cases, the A/B order of the toggle, capture of counts and mode at pulse start, the toggle advancing after an aborted pulse, and the free-running period.

// File: rtl/pulse_steer_pkg.sv
package pulse_steer_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ON   = 2'd1,
        PH_REC  = 2'd2
    } phase_e;

    typedef struct packed {
        logic a;
        logic b;
    } drive_t;

    // Channel enables for one pulse: unison fires both, otherwise sel picks.
    function automatic drive_t pick_drive(input logic sel, input logic uni);
        drive_t d;
        d.a = uni | ~sel;
        d.b = uni | sel;
        return d;
    endfunction

endpackage

// File: rtl/pulse_timer.sv
module pulse_timer
    import pulse_steer_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             lock_i,
    input  logic             abort_i,
    input  logic [CNT_W-1:0] on_cnt_i,
    input  logic [CNT_W-1:0] dead_cnt_i,
    output logic             launch_o,
    output logic             end_o,
    output logic             on_next_o,
    output logic             busy_o
);

    localparam logic [CNT_W-1:0] ZERO = '0;

    phase_e           ph_q, ph_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] dead_q, dead_d;

    // Index of the last cycle of an interval; a zero count behaves as one.
    function automatic logic [CNT_W-1:0] last_idx(input logic [CNT_W-1:0] c);
        return (c == ZERO) ? ZERO : c - 1'b1;
    endfunction

    assign launch_o = (ph_q == PH_IDLE) && start_i && !lock_i && !abort_i;

    always_comb begin
        ph_d   = ph_q;
        cnt_d  = cnt_q;
        dead_d = dead_q;
        end_o  = 1'b0;
        if (lock_i) begin
            ph_d  = PH_IDLE;
            cnt_d = ZERO;
        end else begin
            case (ph_q)
                PH_IDLE: begin
                    if (launch_o) begin
                        ph_d   = PH_ON;
                        cnt_d  = last_idx(on_cnt_i);
                        dead_d = dead_cnt_i;
                    end
                end
                PH_ON: begin
                    if (abort_i || cnt_q == ZERO) begin
                        ph_d  = PH_REC;
                        cnt_d = last_idx(dead_q);
                        end_o = 1'b1;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                PH_REC: begin
                    if (cnt_q == ZERO) ph_d = PH_IDLE;
                    else               cnt_d = cnt_q - 1'b1;
                end
                default: ph_d = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            cnt_q  <= ZERO;
            dead_q <= ZERO;
        end else begin
            ph_q   <= ph_d;
            cnt_q  <= cnt_d;
            dead_q <= dead_d;
        end
    end

    assign on_next_o = (ph_d == PH_ON);
    assign busy_o    = (ph_q != PH_IDLE);

    // R6
    rec_no_relaunch_chk: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_REC) |=> (ph_q != PH_ON));

endmodule

// File: rtl/pulse_router.sv
module pulse_router
    import pulse_steer_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   lock_i,
    input  logic   launch_i,
    input  logic   end_i,
    input  logic   on_next_i,
    input  logic   unison_i,
    output drive_t drv_o
);

    logic   sel_q;
    logic   uni_q;
    logic   uni_n;
    drive_t en;

    assign uni_n = launch_i ? unison_i : uni_q;
    assign en    = pick_drive(sel_q, uni_n);

    always_ff @(posedge clk) begin
        if (rst || lock_i) begin
            sel_q <= 1'b0;
            uni_q <= 1'b0;
            drv_o <= '0;
        end else begin
            if (end_i) sel_q <= ~sel_q;
            uni_q   <= uni_n;
            drv_o.a <= on_next_i & en.a;
            drv_o.b <= on_next_i & en.b;
        end
    end

    // R4
    alt_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !uni_q |-> !(drv_o.a && drv_o.b));

    // R5
    unison_pair_chk: assert property (@(posedge clk) disable iff (rst)
        uni_q |-> (drv_o.a == drv_o.b));

endmodule

// File: rtl/pulse_steer_top.sv
module pulse_steer_top
    import pulse_steer_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             unison_i,
    input  logic [CNT_W-1:0] on_cnt_i,
    input  logic [CNT_W-1:0] dead_cnt_i,
    input  logic             lockout_i,
    input  logic             abort_i,
    output logic             drv_a_o,
    output logic             drv_b_o,
    output logic             busy_o
);

    logic   launch, pend, on_next;
    drive_t drv;

    pulse_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .lock_i     (lockout_i),
        .abort_i    (abort_i),
        .on_cnt_i   (on_cnt_i),
        .dead_cnt_i (dead_cnt_i),
        .launch_o   (launch),
        .end_o      (pend),
        .on_next_o  (on_next),
        .busy_o     (busy_o)
    );

    pulse_router u_router (
        .clk       (clk),
        .rst       (rst),
        .lock_i    (lockout_i),
        .launch_i  (launch),
        .end_i     (pend),
        .on_next_i (on_next),
        .unison_i  (unison_i),
        .drv_o     (drv)
    );

    assign drv_a_o = drv.a;
    assign drv_b_o = drv.b;

    // R9
    lockout_safe_chk: assert property (@(posedge clk) disable iff (rst)
        lockout_i |=> (!drv_a_o && !drv_b_o && !busy_o));

    // R8
    abort_cut_chk: assert property (@(posedge clk) disable iff (rst)
        ((drv_a_o || drv_b_o) && abort_i) |=> (!drv_a_o && !drv_b_o));

    // R2
    drive_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (drv_a_o || drv_b_o) |-> busy_o);

endmodule

// File: tb/sim_pulse_steer_top.sv
module sim_pulse_steer_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic       unison_i = 1'b0;
    logic [7:0] on_cnt_i = '0;
    logic [7:0] dead_cnt_i = '0;
    logic       lockout_i = 1'b0;
    logic       abort_i = 1'b0;
    logic       drv_a_o, drv_b_o, busy_o;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;
    bit  sel    = 1'b0;

    always #5 clk = ~clk;

    pulse_steer_top #(.CNT_W(8)) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .unison_i(unison_i),
        .on_cnt_i(on_cnt_i), .dead_cnt_i(dead_cnt_i), .lockout_i(lockout_i),
        .abort_i(abort_i), .drv_a_o(drv_a_o), .drv_b_o(drv_b_o), .busy_o(busy_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_out(input string tag, input bit ea, input bit eb, input bit ebusy);
        chk(drv_a_o == ea, {tag, " drv_a"}, drv_a_o, ea);
        chk(drv_b_o == eb, {tag, " drv_b"}, drv_b_o, eb);
        chk(busy_o == ebusy, {tag, " busy"}, busy_o, ebusy);
    endtask

    // One pulse with on=1, dead=1, then wait until idle.
    task automatic short_pulse(input string tag, input bit ea, input bit eb);
        @(negedge clk); start_i = 1; on_cnt_i = 1; dead_cnt_i = 1; unison_i = 0;
        @(negedge clk); start_i = 0;
        chk_out(tag, ea, eb, 1);
        @(negedge clk);
        @(negedge clk);
        chk_out({tag, " idle"}, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk_out("R1 reset", 0, 0, 0);

        // Sweep of mode, on-time and recovery counts
        for (int u = 0; u < 2; u++) begin
            for (int n = 0; n < 5; n++) begin
                for (int d = 0; d < 4; d++) begin
                    int  en, ed;
                    bit  ea, eb;
                    string ton, tdd, tmode;
                    en = (n == 0) ? 1 : n;
                    ed = (d == 0) ? 1 : d;
                    ea = (u == 1) || !sel;
                    eb = (u == 1) || sel;
                    ton   = (n == 0) ? "R3 on-zero" : "R2 R7 on";
                    tdd   = (d == 0) ? "R3 dead-zero" : "R6 R7 dead";
                    tmode = (u == 1) ? "R5 R11 unison" : "R4 R11 alternate";
                    @(negedge clk);
                    start_i = 1; unison_i = u[0]; on_cnt_i = n[7:0]; dead_cnt_i = d[7:0];
                    @(negedge clk);
                    start_i = 0; unison_i = !u[0]; on_cnt_i = 8'd7; dead_cnt_i = 8'd6;
                    for (int k = 0; k < en; k++) begin
                        if (k > 0) @(negedge clk);
                        chk_out({ton, " ", tmode}, ea, eb, 1);
                    end
                    for (int k = 0; k < ed; k++) begin
                        @(negedge clk);
                        start_i = (k == 0);
                        chk_out(tdd, 0, 0, 1);
                    end
                    @(negedge clk);
                    start_i = 0;
                    chk_out("R6 idle after recovery", 0, 0, 0);
                    sel = !sel;
                end
            end
        end

        // Abort in mid-pulse
        @(negedge clk); lockout_i = 1;
        @(negedge clk); lockout_i = 0;
        chk_out("R1 R9 lockout idle", 0, 0, 0);
        start_i = 1; on_cnt_i = 5; dead_cnt_i = 2; unison_i = 0;
        @(negedge clk); start_i = 0;
        chk_out("R8 pre-abort", 1, 0, 1);
        @(negedge clk);
        abort_i = 1;
        chk_out("R8 pre-abort", 1, 0, 1);
        @(negedge clk); abort_i = 0;
        chk_out("R8 cut", 0, 0, 1);
        @(negedge clk);
        chk_out("R8 recovery", 0, 0, 1);
        @(negedge clk);
        chk_out("R8 idle", 0, 0, 0);
        // Strobe together with fault is ignored
        start_i = 1; abort_i = 1;
        @(negedge clk); start_i = 0; abort_i = 0;
        chk_out("R8 strobe under fault", 0, 0, 0);
        short_pulse("R8 toggle advanced", 0, 1);
        short_pulse("R4 back to A", 1, 0);

        // Lockout in mid-pulse: now B is next
        @(negedge clk); start_i = 1; on_cnt_i = 6; dead_cnt_i = 3;
        @(negedge clk); start_i = 0;
        chk_out("R4 B pulse", 0, 1, 1);
        lockout_i = 1;
        @(negedge clk);
        start_i = 1;
        chk_out("R9 lockout cut", 0, 0, 0);
        @(negedge clk);
        chk_out("R9 strobe under lockout", 0, 0, 0);
        @(negedge clk);
        start_i = 0; lockout_i = 0;
        chk_out("R9 still idle", 0, 0, 0);
        short_pulse("R1 R9 A first", 1, 0);

        // Free-run in unison: on=2, dead=1, period 4
        @(negedge clk);
        start_i = 1; unison_i = 1; on_cnt_i = 2; dead_cnt_i = 1;
        for (int k = 1; k <= 12; k++) begin
            bit e;
            @(negedge clk);
            e = ((k - 1) % 4) < 2;
            chk_out("R10 free-run", e, e, ((k - 1) % 4) < 3);
        end
        start_i = 0;

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule